// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs clause 22 management transactions between a host register interface and one external PHY, using the MDC clock and the MDIO data line. Software first loads a 16-bit write-data register when it needs to write. It then writes a 16-bit command word holding the operation, the PHY address and the register number. The block sends a complete management frame and clocks MDC while it does so. For a read, it releases MDIO for the turnaround and data phases and collects the 16 bits the PHY returns.

Every operation is started by its own command bit. The host can read that bit back as 1 for as long as the frame is running, and it returns to 0 by itself when the frame ends. Software therefore polls the bit it set to learn when the operation is complete. For a read, it then collects the result from a separate read-data register. MDC comes from the system clock through a parameterised divider. A command written while a frame is in flight is dropped.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, `cmd_status` and `rd_data` read 0, `mdc` is low and `mdio_oe` is low.
- R2: A command-register write with bit 14 set and bit 13 clear starts a write frame. MDIO is driven for all 64 bits, in this order: 32 ones, start code 01, opcode 01, a 5-bit PHY address from command bits 12:8 (MSB first), a 5-bit register number from bits 4:0 (MSB first), turnaround 10, and then the write-data register MSB first.
- R3: A command with bit 13 set and bit 14 clear starts a read frame. The frame carries the same preamble, start code, address and register fields as a write, but with opcode 10. `mdio_oe` is low for the last 18 bits (turnaround and data). The 16 data bits are sampled on MDC rising edges, MSB first, and appear in `rd_data` once the command bit has cleared.
- R4: `cmd_status` bit 14 (write) or bit 13 (read) reads 1 from the cycle after the command is accepted until the frame ends, and then clears on its own. Bits 12:8 and 4:0 return the accepted PHY address and register number. Bits 15 and 7:5 read 0. At most one of bits 14 and 13 is ever set.
- R5: MDC is low while idle. Each half period lasts DIV_HALF system clocks, and the first rising edge comes DIV_HALF clocks after acceptance. The busy bit stays set for exactly 128*DIV_HALF clocks, which is 64 MDC periods.
- R6: `mdio_o` and `mdio_oe` change only at MDC falling edges or at frame start. They hold still while MDC is high.
- R7: A command written while a frame is running is ignored. It changes neither the frame on the wire nor the fields read back, and it starts no further frame.
- R8: A command with both bits 14 and 13 set, or with neither set, is ignored. No MDC edges follow and the busy bits stay 0.
- R9: The write-data value is captured when the command is accepted. A write-data register write during a frame does not alter the data bits sent.
- R10: A write transaction leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Target register: 0 selects the command word, 1 selects write data |
| reg_wdata | input | 16 | Value written to the selected register |
| cmd_status | output | 16 | Command word readback; bits 14/13 act as the busy flags |
| rd_data | output | 16 | Data returned by the last completed read |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value to the pad |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |

## Verification
The assertions rely on a few conditions at the inputs:
- `reg_we` is a single-cycle strobe.
- DIV_HALF is at least 2, so that MDC rising and falling edges fall in different system cycles.
- `mdio_i` is stable at every MDC rising edge.

The stimulus keeps to these conditions. The PHY model changes `mdio_i` only in the cycle after it has seen a rising MDC edge, so the level is steady for a full MDC period before the next sample. Every register write is issued as a one-cycle pulse between falling clock edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // command word bit positions (software-visible encoding)
  localparam int CMD_WR_BIT = 14;
  localparam int CMD_RD_BIT = 13;
  localparam int PHY_LSB    = 8;
  localparam int FLD_W      = 5;

  // frame geometry
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input mdio_op_e         op,
    input logic [FLD_W-1:0] phy,
    input logic [FLD_W-1:0] regn,
    input logic [15:0]      data
  );
    logic [1:0]  ta;
    logic [15:0] d;
    ta = (op == OP_WRITE) ? 2'b10 : 2'b11;
    d  = (op == OP_WRITE) ? data : 16'hFFFF;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regn, ta, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV_HALF);

  logic [CW-1:0] cnt;
  logic          term;

  assign term      = run && (cnt == CW'(DIV_HALF - 1));
  assign rise_tick = term && !mdc;
  assign fall_tick = term && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R5
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);

  // R5
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(mdc)) |-> $past(cnt) == CW'(DIV_HALF - 1));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_op_e         op,
  input  logic [FLD_W-1:0] phy,
  input  logic [FLD_W-1:0] regn,
  input  logic [15:0]      wdata,
  input  logic             mdc,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      rdata
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [IW-1:0]        idx;
  logic                 is_read;
  logic [15:0]          rx;
  logic                 last_bit;

  assign mdio_o   = shreg[FRAME_LEN-1];
  assign last_bit = (idx == IW'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      mdio_oe <= 1'b0;
      rx      <= '0;
      rdata   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      is_read <= (op == OP_READ);
      shreg   <= build_frame(op, phy, regn, wdata);
      idx     <= '0;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tick && is_read && idx >= IW'(DATA_IDX))
        rx <= {rx[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_read) rdata <= rx;
        end else begin
          idx   <= idx + IW'(1);
          shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
          if (is_read && idx == IW'(TA_IDX - 1))
            mdio_oe <= 1'b0;
        end
      end
    end
  end

  // R6
  mdio_hold_hi_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(idx) == IW'(FRAME_LEN - 1));

  // R10
  rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_read) |=> $stable(rdata));
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] cmd_status,
  output logic [15:0] rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic             busy;
  logic             rise_tick;
  logic             fall_tick;
  logic             cmd_we;
  logic             want_wr;
  logic             want_rd;
  logic             accept;
  mdio_op_e         op_req;
  mdio_op_e         op_q;
  logic [FLD_W-1:0] phy_q;
  logic [FLD_W-1:0] reg_q;
  logic [15:0]      wdata_q;
  logic             unused_bits;

  assign cmd_we  = reg_we && !reg_sel;
  assign want_wr = reg_wdata[CMD_WR_BIT];
  assign want_rd = reg_wdata[CMD_RD_BIT];
  assign accept  = cmd_we && !busy && (want_wr ^ want_rd);
  assign op_req  = want_wr ? OP_WRITE : OP_READ;
  assign unused_bits = ^{reg_wdata[15], reg_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_WRITE;
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (reg_we && reg_sel)
        wdata_q <= reg_wdata;
      if (accept) begin
        op_q  <= op_req;
        phy_q <= reg_wdata[PHY_LSB +: FLD_W];
        reg_q <= reg_wdata[FLD_W-1:0];
      end
    end
  end

  always_comb begin
    cmd_status                      = '0;
    cmd_status[CMD_WR_BIT]          = busy && (op_q == OP_WRITE);
    cmd_status[CMD_RD_BIT]          = busy && (op_q == OP_READ);
    cmd_status[PHY_LSB +: FLD_W]    = phy_q;
    cmd_status[FLD_W-1:0]           = reg_q;
  end

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) clk_i (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng eng_i (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .op        (op_req),
    .phy       (reg_wdata[PHY_LSB +: FLD_W]),
    .regn      (reg_wdata[FLD_W-1:0]),
    .wdata     (wdata_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rdata     (rd_data)
  );

  // R4
  busy_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_status[CMD_WR_BIT:CMD_RD_BIT]));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_we) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));

  // R8
  bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_we && (want_wr == want_rd)) |=> !busy);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (cmd_status[CMD_WR_BIT] || cmd_status[CMD_RD_BIT]));
endmodule

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb_top;
  localparam int H = 4;
  localparam int NV = 6;
  // {is_read, phy, reg, data (write) or PHY response (read)}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd0,  16'h2C41},
    {1'b1, 5'd1,  5'd1,  16'h786D},
    {1'b0, 5'd31, 5'd31, 16'hA5C3},
    {1'b1, 5'd0,  5'd0,  16'h8001},
    {1'b0, 5'd0,  5'd4,  16'h01E1},
    {1'b1, 5'd31, 5'd31, 16'h5F3A}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] cmd_status;
  logic [15:0] rd_data;
  logic        mdc;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;

  int n_chk = 0;
  int n_bad = 0;
  int nrise = 0;
  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  logic [15:0] resp = '0;

  always #2.5 clk = ~clk;

  mdio_ctrl #(.DIV_HALF(H)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_status(cmd_status), .rd_data(rd_data),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY model: samples at MDC rise, drives read data after each rise
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (mdc && !prev) begin
        if (nrise < 64) begin
          cap_o[63-nrise]  = mdio_o;
          cap_oe[63-nrise] = mdio_oe;
        end
        nrise++;
      end
      prev = mdc;
      mdio_i = (nrise >= 48 && nrise < 64) ? resp[63-nrise] : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] cmd_word(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg);
    return {1'b0, ~rd, rd, phy, 3'b000, rg};
  endfunction

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while ((cmd_status[14] || cmd_status[13]) && cycles < 2000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] rd_before;
    logic [63:0] exp_f, mask;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmd_status == 16'h0, "R1 cmd_status", 64'(cmd_status), 64'h0);
    check(rd_data == 16'h0, "R1 rd_data", 64'(rd_data), 64'h0);
    check({mdc, mdio_oe} == 2'b00, "R1 mdc/oe", 64'({mdc, mdio_oe}), 64'h0);

    for (int v = 0; v < NV; v++) begin
      logic rd; logic [4:0] phy, rg; logic [15:0] dat;
      {rd, phy, rg, dat} = VEC[v];
      rd_before = rd_data;
      resp = rd ? dat : 16'h0;
      cap_o = '0; cap_oe = '0; nrise = 0;
      if (!rd) write_reg(1'b1, dat);
      write_reg(1'b0, cmd_word(rd, phy, rg));
      // R4 busy bit and fields readback
      check(cmd_status == {1'b0, ~rd, rd, phy, 3'b000, rg}, "R4 status while busy",
            64'(cmd_status), 64'({1'b0, ~rd, rd, phy, 3'b000, rg}));
      wait_idle(cyc);
      check(cyc == 128 * H, "R5 busy duration", 64'(cyc), 64'(128 * H));
      check(cmd_status == {3'b000, phy, 3'b000, rg}, "R4 self-clear",
            64'(cmd_status), 64'({3'b000, phy, 3'b000, rg}));
      check(nrise == 64, "R5 MDC periods", 64'(nrise), 64'd64);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R5 idle after frame",
            64'({mdc, mdio_oe}), 64'h0);
      exp_f = {32'hFFFFFFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, dat};
      mask  = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
      if (rd) begin
        check((cap_o & mask) == (exp_f & mask), "R3 read frame header", cap_o & mask,
              exp_f & mask);
        check(cap_oe == mask, "R3 release for TA/data", cap_oe, mask);
        check(rd_data == dat, "R3 rd_data", 64'(rd_data), 64'(dat));
      end else begin
        check(cap_o == exp_f, "R2 write frame", cap_o, exp_f);
        check(cap_oe == mask, "R2 oe throughout", cap_oe, mask);
        check(rd_data == rd_before, "R10 rd_data kept", 64'(rd_data), 64'(rd_before));
      end
    end

    // R8: both bits and neither bit set are ignored
    nrise = 0;
    write_reg(1'b0, 16'h6305);
    repeat (4 * H) @(negedge clk);
    check(cmd_status[14:13] == 2'b00 && nrise == 0, "R8 both bits ignored",
          64'({cmd_status[14:13], 8'(nrise)}), 64'h0);
    write_reg(1'b0, 16'h0305);
    repeat (4 * H) @(negedge clk);
    check(cmd_status[14:13] == 2'b00 && nrise == 0, "R8 no bit ignored",
          64'({cmd_status[14:13], 8'(nrise)}), 64'h0);

    // R7 / R9: command and write-data writes during a frame
    cap_o = '0; nrise = 0; resp = 16'h0;
    write_reg(1'b1, 16'h1234);
    write_reg(1'b0, cmd_word(1'b0, 5'd3, 5'd5));
    repeat (50) @(negedge clk);
    write_reg(1'b0, cmd_word(1'b1, 5'd7, 5'd9));
    write_reg(1'b1, 16'hFFFF);
    wait_idle(cyc);
    exp_f = {32'hFFFFFFFF, 2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'h1234};
    check(cap_o == exp_f, "R9 frame data kept", cap_o, exp_f);
    check(cmd_status == {3'b000, 5'd3, 3'b000, 5'd5}, "R7 fields kept",
          64'(cmd_status), 64'({3'b000, 5'd3, 3'b000, 5'd5}));
    repeat (40 * H) @(negedge clk);
    check(nrise == 64 && cmd_status[14:13] == 2'b00, "R7 no second frame",
          64'(nrise), 64'd64);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule